// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a system clock into the oversampling tick that a UART transmitter and receiver share. The divisor is loaded as a 12-bit whole part and a 4-bit part counted in sixteenths. A divisor of 208.375, for example, is loaded as whole part 0xD0 and sixteenths 0x6. The divisor equals the clock frequency divided by the product of the oversampling factor and the baud rate. That figure is worked out elsewhere and loaded by a one-cycle load strobe.

Each tick period lasts either the whole part or the whole part plus one clock. A 4-bit remainder accumulator gains the sixteenths at every tick. When it wraps, the period that follows is one clock longer, so over time the mean period matches the loaded value. An oversampling select captured at load picks 8 or 16 ticks per bit. A bit strobe marks the first tick of every such group. A whole part of zero holds the generator silent.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, and before any load, `tick` and `bit_strobe` stay low.
- R2: Call cycle 0 the first cycle after the clock edge that samples `div_load` high. With sixteenths F = 0 and whole part I > 0, `tick` is high exactly in cycles k*I - 1 for k = 1, 2, 3, ...
- R3: With F > 0, `tick` is high exactly in cycles k*I + floor((k-1)*F/16) - 1 for k = 1, 2, 3, .... Every period is therefore I or I+1 cycles long.
- R4: Whole part 0xD0 with sixteenths 0x6 (208.375) gives a first tick at cycle 207. Ticks 1 and 17 are exactly 16*208+6 = 3334 cycles apart.
- R5: A loaded whole part of zero produces no `tick` and no `bit_strobe`.
- R6: A load in the middle of a run restarts the period counter, the remainder accumulator and the tick group counter, so timing follows R2/R3 from the new cycle 0.
- R7: With `os_sel` = 0 captured at load (16x), `bit_strobe` is high exactly with ticks k where (k-1) mod 16 = 0.
- R8: With `os_sel` = 1 captured at load (8x), `bit_strobe` is high exactly with ticks k where (k-1) mod 8 = 0.
- R9: `div_int`, `div_frac` and `os_sel` are sampled only while `div_load` is high. Changing them at other times has no effect on `tick` or `bit_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_load | input | 1 | One-cycle strobe that captures divisor and mode and restarts timing |
| div_int | input | 12 | Whole part of the divisor |
| div_frac | input | 4 | Sixteenths part of the divisor |
| os_sel | input | 1 | Oversampling select: 0 = 16 ticks per bit, 1 = 8 ticks per bit |
| tick | output | 1 | One oversampling tick |
| bit_strobe | output | 1 | High with the first tick of each group of 8 or 16 |

## Verification
A wrong remainder state shows as one tick landing a cycle early or late against the closed-form cycle k*I + floor((k-1)*F/16) - 1. The fault is visible within at most 16 ticks of the load, because the remainder pattern repeats every 16 periods. A stale period count or group count shows on the very first tick or strobe after a load. A divisor or mode that leaks through without a load changes tick spacing at the next period boundary. The bench sweeps every sixteenths value over small whole parts in both modes, and scrambles the inputs after every load.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
   typedef enum logic {
      OS_X16 = 1'b0,
      OS_X8  = 1'b1
   } os_mode_e;

   localparam int unsigned GRP_W = 4;
endpackage

// File: rtl/bfg_frac_acc.sv
module bfg_frac_acc #(
   parameter int unsigned FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [FRAC_W-1:0] frac,
   output logic              extra
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;

   assign sum = {1'b0, acc_q} + {1'b0, frac};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         extra <= 1'b0;
      end else if (clr) begin
         acc_q <= '0;
         extra <= 1'b0;
      end else if (adv) begin
         acc_q <= sum[FRAC_W-1:0];
         extra <= sum[FRAC_W];
      end
   end

   // R6: a load empties the remainder and cancels a pending long period
   a_r6_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0) && !extra);
endmodule

// File: rtl/bfg_period_cnt.sv
module bfg_period_cnt #(
   parameter int unsigned INT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [INT_W-1:0] int_part,
   input  logic             extra,
   output logic             tick
);
   localparam int unsigned LEN_W = INT_W + 1;

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len;

   assign len  = {1'b0, int_part} + {{INT_W{1'b0}}, extra};
   assign tick = run && (cnt_q == len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || !run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   // R3: the count never passes the current period length
   a_r3_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < len));

   // R6: a load restarts the period
   a_r6_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
endmodule

// File: rtl/bfg_os_div.sv
module bfg_os_div
   import bfg_pkg::*;
#(
   parameter bit OS_SELECTABLE = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     tick,
   input  os_mode_e mode,
   output logic     bit_strobe
);
   os_mode_e          mode_eff;
   logic [GRP_W-1:0]  grp_q;
   logic [GRP_W-1:0]  last;

   generate
      if (OS_SELECTABLE) begin : g_sel
         assign mode_eff = mode;
      end else begin : g_fixed
         assign mode_eff = OS_X16;
      end
   endgenerate

   assign last       = (mode_eff == OS_X8) ? GRP_W'(7) : GRP_W'(15);
   assign bit_strobe = tick && (grp_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         grp_q <= '0;
      else if (clr)
         grp_q <= '0;
      else if (tick)
         grp_q <= (grp_q >= last) ? '0 : grp_q + 1'b1;
   end

   // R7/R8: a strobe only ever accompanies a tick
   a_r7_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |-> tick);

   // R8: in 8x mode the group index stays below eight
   a_r8_group_range: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && mode_eff == OS_X8 && $past(mode_eff) == OS_X8) |-> (grp_q < GRP_W'(8)));
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
   import bfg_pkg::*;
#(
   parameter int unsigned INT_W         = 12,
   parameter int unsigned FRAC_W        = 4,
   parameter bit          OS_SELECTABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              div_load,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   input  logic              os_sel,
   output logic              tick,
   output logic              bit_strobe
);
   generate
      if (INT_W < 1 || INT_W > 24) begin : g_bad_int
         $error("baud_frac_gen: INT_W out of range");
      end
      if (FRAC_W < 1 || FRAC_W > 8) begin : g_bad_frac
         $error("baud_frac_gen: FRAC_W out of range");
      end
   endgenerate

   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;
   os_mode_e          mode_q;
   logic              run;
   logic              extra;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q  <= '0;
         frac_q <= '0;
         mode_q <= OS_X16;
      end else if (div_load) begin
         int_q  <= div_int;
         frac_q <= div_frac;
         mode_q <= os_mode_e'(os_sel);
      end
   end

   assign run = (int_q != '0);

   bfg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (div_load),
      .adv   (tick),
      .frac  (frac_q),
      .extra (extra)
   );

   bfg_period_cnt #(.INT_W(INT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (div_load),
      .run      (run),
      .int_part (int_q),
      .extra    (extra),
      .tick     (tick)
   );

   bfg_os_div #(.OS_SELECTABLE(OS_SELECTABLE)) u_os (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (div_load),
      .tick       (tick),
      .mode       (mode_q),
      .bit_strobe (bit_strobe)
   );

   // R5: a zero whole part keeps both outputs quiet
   a_r5_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (int_q == '0) |-> (!tick && !bit_strobe));

   // R9: captured divisor only moves on a load
   a_r9_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(div_load) && $past(rst_n) |-> $stable(int_q) && $stable(frac_q));
endmodule

// File: tb/baud_frac_gen_bench.sv
module baud_frac_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        div_load = 1'b0;
   logic [11:0] div_int = '0;
   logic [3:0]  div_frac = '0;
   logic        os_sel = 1'b0;
   logic        tick;
   logic        bit_strobe;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   baud_frac_gen u_baud_frac_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_load   (div_load),
      .div_int    (div_int),
      .div_frac   (div_frac),
      .os_sel     (os_sel),
      .tick       (tick),
      .bit_strobe (bit_strobe)
   );

   task automatic cmp(input string tag, input logic got, input logic exp, input int m);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b at cycle %0d (I=%0d F=%0d os=%0b)",
                  tag, got, exp, m, div_int, div_frac, os_sel);
      end
   endtask

   // Load a divisor, scramble inputs (R9), then compare for ncyc cycles.
   task automatic run_case(input int ii, input int ff, input bit md, input int ncyc,
                           input string extra_tag);
      int    k;
      int    grp;
      int    next_t;
      bit    t_exp;
      bit    s_exp;
      string ttag;
      string stag;
      @(negedge clk);
      div_int  = 12'(ii);
      div_frac = 4'(ff);
      os_sel   = md;
      div_load = 1'b1;
      @(negedge clk);
      div_load = 1'b0;
      div_int  = 12'(ii) ^ 12'h5A3;
      div_frac = 4'(ff) ^ 4'h9;
      os_sel   = ~md;
      grp  = md ? 8 : 16;
      ttag = (ii == 0) ? "R5" : ((ff == 0) ? "R2" : "R3");
      stag = (ii == 0) ? "R5" : (md ? "R8" : "R7");
      ttag = {ttag, "/R9", extra_tag};
      stag = {stag, "/R9", extra_tag};
      k = 1;
      for (int m = 0; m < ncyc; m++) begin
         next_t = k * ii + ((k - 1) * ff) / 16;
         t_exp  = (ii != 0) && (m == next_t - 1);
         s_exp  = t_exp && (((k - 1) % grp) == 0);
         cmp(ttag, tick, t_exp, m);
         cmp(stag, bit_strobe, s_exp, m);
         if (t_exp) k++;
         @(negedge clk);
      end
   endtask

   initial begin
      #4_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int t1;
      int t17;
      int kk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: quiet after reset with nothing loaded
      for (int m = 0; m < 20; m++) begin
         cmp("R1", tick, 1'b0, m);
         cmp("R1", bit_strobe, 1'b0, m);
         @(negedge clk);
      end
      // R5: zero whole part, with a nonzero fraction
      run_case(0, 11, 1'b0, 60, "");
      // R2/R3/R7/R8/R9 sweep
      for (int ii = 1; ii <= 6; ii++)
         for (int ff = 0; ff < 16; ff++)
            for (int md = 0; md < 2; md++)
               run_case(ii, ff, md[0], 180, "");
      // R6: reload mid-period from a non-trivial state
      run_case(7, 9, 1'b1, 53, "/R6");
      run_case(7, 9, 1'b1, 200, "/R6");
      run_case(3, 5, 1'b0, 200, "/R6");
      // R4: 208.375 encoded as 0xD0 / 0x6
      @(negedge clk);
      div_int  = 12'hD0;
      div_frac = 4'h6;
      os_sel   = 1'b0;
      div_load = 1'b1;
      @(negedge clk);
      div_load = 1'b0;
      t1 = -1; t17 = -1; kk = 0;
      for (int m = 0; m < 3700; m++) begin
         if (tick) begin
            kk++;
            if (kk == 1)  t1  = m;
            if (kk == 17) t17 = m;
         end
         @(negedge clk);
      end
      n_chk++;
      if (t1 != 207) begin
         n_bad++;
         $display("FAIL R4: first tick at %0d expected 207", t1);
      end
      n_chk++;
      if (t17 - t1 != 3334) begin
         n_bad++;
         $display("FAIL R4: 16-period span %0d expected 3334", t17 - t1);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule